// File: doc/BRIEF.md
# Loopback Status Latch

This block keeps a one-bit, per-packet verdict on whether an attachment-unit port returns what it sends. While the port transmits, a carrier-sense input is high, and a match input reports each cycle whether the data coming back equals the data sent out. Any mismatch seen while carrier is high is remembered. When carrier drops at the end of the packet, that record is combined with the port-disabled and reverse-mode flags. The result is latched into a status bit.

The status bit then stays fixed until the next packet ends. It drives an LED output, which is active low by default so that an open-drain pin can sink current to light the lamp. Reset clears the status, so the lamp is dark until the first clean packet completes. All inputs are assumed to be synchronous to `clk`.

Top module: `lbk_status_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `lb_ok` goes to 0 after that edge. With the default polarity, `lb_led_n` goes to 1 (lamp dark).
- R2: Suppose a packet is a run of cycles with `tx_crs` = 1, and `lb_match` = 1 (data returned equal) in every one of them. If `port_dis` = 0 and `rev_mode` = 0 in the first cycle with `tx_crs` = 0, then `lb_ok` is 1 one clock after that cycle.
- R3: If `lb_match` = 0 in any cycle of a packet, `lb_ok` is 0 one clock after the packet ends. This includes the first and the last cycle of the packet.
- R4: If `port_dis` = 1 in the cycle where `tx_crs` falls, the result is 0. A `port_dis` pulse that is inside the packet and gone by the end cycle has no effect.
- R5: If `rev_mode` = 1 in the cycle where `tx_crs` falls, the result is 0. A `rev_mode` pulse that is inside the packet and gone by the end cycle has no effect.
- R6: `lb_ok` changes only one clock after an end of packet, or through reset. It holds its value while a packet is running and while the line is idle, whatever `lb_match`, `port_dis` and `rev_mode` do.
- R7: A mismatch in one packet does not carry into the next. A clean packet that follows a failed one gives `lb_ok` = 1.
- R8: With `LED_ACTIVE_LOW` = 1 (the default), `lb_led_n` is always the inverse of `lb_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_crs | input | 1 | Transmit carrier sense; high for the length of a packet |
| lb_match | input | 1 | 1 when the returned data equals the sent data this cycle |
| port_dis | input | 1 | Port disabled flag |
| rev_mode | input | 1 | Port in reverse mode |
| lb_ok | output | 1 | Latched loopback-good status |
| lb_led_n | output | 1 | LED drive (active low by default) |

## Verification
The mismatch record is hidden state, so the bench can only see it through `lb_ok` one clock after the packet ends. Two faults show up there. A record that fails to stick makes a failed packet read as good. A record that fails to clear at the next carrier rise makes the good packet after a failed one read as bad. A wrong edge detector or a missing enable on the status register shows up differently: `lb_ok` moves in the middle of a packet or during idle, or it moves one cycle off from the end of packet. The bench therefore checks the hold at the last cycle of every packet and over several idle cycles.

// File: rtl/lbk_pkg.sv
// Package: shared types and the verdict rule for the loopback status latch.
// Assumes: all fields are sampled in the end-of-packet cycle.
package lbk_pkg;

    // Conditions sampled at the end of a packet
    typedef struct packed {
        logic pkt_err;   // a mismatch was seen during the packet
        logic dis;       // port disabled at the end cycle
        logic rev;       // reverse mode at the end cycle
    } lbk_sample_t;

    // Loopback is good only with no error and the port enabled in forward mode
    function automatic logic lbk_verdict(input lbk_sample_t s);
        return !(s.pkt_err || s.dis || s.rev);
    endfunction

endpackage

// File: rtl/lbk_edge_detect.sv
// Module: finds the start and end of a packet on the carrier-sense input.
// Assumes: crs_in is synchronous to clk; each event pulse lasts one cycle.
module lbk_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic crs_in,
    output logic rise_evt,
    output logic fall_evt
);
    logic crs_d;

    // Keep last cycle's carrier value
    always_ff @(posedge clk) begin
        if (!rst_n) crs_d <= 1'b0;
        else        crs_d <= crs_in;
    end

    assign rise_evt = crs_in & ~crs_d;
    assign fall_evt = ~crs_in & crs_d;
endmodule

// File: rtl/lbk_err_tracker.sv
// Module: sticky mismatch flag for the current packet.
// Assumes: rise_evt marks the first carrier cycle; match is valid while active.
module lbk_err_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_evt,
    input  logic active,
    input  logic match,
    output logic err_q
);
    // Restart on a new packet, then hold any mismatch until the next start
    always_ff @(posedge clk) begin
        if (!rst_n)                err_q <= 1'b0;
        else if (rise_evt)         err_q <= ~match;
        else if (active && !match) err_q <= 1'b1;
    end
endmodule

// File: rtl/lbk_status_reg.sv
// Module: latches the verdict once per packet end.
// Assumes: end_evt is a single-cycle pulse.
module lbk_status_reg
    import lbk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        end_evt,
    input  lbk_sample_t sample,
    output logic        status_q
);
    // Load a new verdict only at the end of a packet
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= 1'b0;
        else if (end_evt) status_q <= lbk_verdict(sample);
    end
endmodule

// File: rtl/lbk_status_latch.sv
// Module: top of the loopback status latch. It tracks mismatches across a
// transmitted packet, samples disable and reverse at carrier fall, holds the
// result and drives the LED.
// Assumes: all inputs are synchronous to clk; the LED polarity is fixed at build.
module lbk_status_latch
    import lbk_pkg::*;
#(
    parameter bit LED_ACTIVE_LOW = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_crs,
    input  logic lb_match,
    input  logic port_dis,
    input  logic rev_mode,
    output logic lb_ok,
    output logic lb_led_n
);
    logic        pkt_start;
    logic        pkt_end;
    logic        pkt_err;
    lbk_sample_t end_sample;

    lbk_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .crs_in   (tx_crs),
        .rise_evt (pkt_start),
        .fall_evt (pkt_end)
    );

    lbk_err_tracker u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (pkt_start),
        .active   (tx_crs),
        .match    (lb_match),
        .err_q    (pkt_err)
    );

    // Gather the end-of-packet conditions
    always_comb begin
        end_sample.pkt_err = pkt_err;
        end_sample.dis     = port_dis;
        end_sample.rev     = rev_mode;
    end

    lbk_status_reg u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_evt  (pkt_end),
        .sample   (end_sample),
        .status_q (lb_ok)
    );

    // LED polarity chosen at build time
    generate
        if (LED_ACTIVE_LOW) begin : g_led_low
            assign lb_led_n = ~lb_ok;
        end else begin : g_led_high
            assign lb_led_n = lb_ok;
        end
    endgenerate
endmodule

// File: rtl/lbk_status_latch_chk.sv
// Module: property checker for lbk_status_latch, attached by bind.
// Assumes: pkt_end and pkt_err are the top's internal end pulse and error flag.
module lbk_status_latch_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_crs,
    input logic lb_match,
    input logic port_dis,
    input logic rev_mode,
    input logic lb_ok,
    input logic pkt_end,
    input logic pkt_err
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !lb_ok);

    assert_good_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && !pkt_err && !port_dis && !rev_mode) |=> lb_ok);

    assert_err_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_crs && !lb_match) |=> pkt_err);

    assert_dis_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && port_dis) |=> !lb_ok);

    assert_rev_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && rev_mode) |=> !lb_ok);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lb_ok) |-> ($past(pkt_end) || !$past(rst_n)));
endmodule

bind lbk_status_latch lbk_status_latch_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_crs   (tx_crs),
    .lb_match (lb_match),
    .port_dis (port_dis),
    .rev_mode (rev_mode),
    .lb_ok    (lb_ok),
    .pkt_end  (pkt_end),
    .pkt_err  (pkt_err)
);

// File: tb/lbk_status_latch_test.sv
// Bench: walks a vector table of packets, then runs directed reset and corner tests.
module lbk_status_latch_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_crs = 1'b0;
    logic lb_match = 1'b1;
    logic port_dis = 1'b0;
    logic rev_mode = 1'b0;
    logic lb_ok;
    logic lb_led_n;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  prev_ok = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    lbk_status_latch uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_crs   (tx_crs),
        .lb_match (lb_match),
        .port_dis (port_dis),
        .rev_mode (rev_mode),
        .lb_ok    (lb_ok),
        .lb_led_n (lb_led_n)
    );

    // Fields: [10:7] length, [6:3] mismatch cycle (15 = none), [2] dis, [1] rev, [0] expected
    localparam int NV = 10;
    localparam logic [10:0] VEC [NV] = '{
        {4'd3, 4'd15, 1'b0, 1'b0, 1'b1},   // R2 clean
        {4'd5, 4'd2,  1'b0, 1'b0, 1'b0},   // R3 mid error
        {4'd6, 4'd15, 1'b0, 1'b0, 1'b1},   // R7 clean after bad
        {4'd4, 4'd0,  1'b0, 1'b0, 1'b0},   // R3 first cycle
        {4'd4, 4'd3,  1'b0, 1'b0, 1'b0},   // R3 last cycle
        {4'd1, 4'd15, 1'b0, 1'b0, 1'b1},   // R7 / R2 single cycle
        {4'd2, 4'd15, 1'b1, 1'b0, 1'b0},   // R4 disabled at end
        {4'd2, 4'd15, 1'b0, 1'b1, 1'b0},   // R5 reverse at end
        {4'd3, 4'd15, 1'b1, 1'b1, 1'b0},   // R4 R5 both
        {4'd1, 4'd0,  1'b0, 1'b0, 1'b0}    // R3 single bad cycle
    };

    task automatic check(input bit act, input bit exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic run_pkt(input int len, input int errpos, input bit dis_mid,
                           input bit rev_mid, input bit dis_end, input bit rev_end,
                           input bit exp, input string tag);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == len - 1) check(lb_ok, prev_ok, {tag, " R6 hold in packet"});
            tx_crs   = 1'b1;
            lb_match = (i != errpos);
            port_dis = dis_mid;
            rev_mode = rev_mid;
        end
        @(negedge clk);
        tx_crs   = 1'b0;
        lb_match = 1'b1;
        port_dis = dis_end;
        rev_mode = rev_end;
        @(negedge clk);
        check(lb_ok, exp, tag);
        check(lb_led_n, !exp, {tag, " R8 led"});
        // idle with noise on the other inputs: status must hold
        lb_match = 1'b0;
        port_dis = !dis_end;
        rev_mode = !rev_end;
        repeat (3) @(negedge clk);
        check(lb_ok, exp, {tag, " R6 hold idle"});
        lb_match = 1'b1;
        port_dis = 1'b0;
        rev_mode = 1'b0;
        prev_ok = exp;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check(lb_ok, 1'b0, "R1 reset status");
        check(lb_led_n, 1'b1, "R1 reset led");
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_pkt(int'(VEC[v][10:7]), int'(VEC[v][6:3]), 1'b0, 1'b0,
                    VEC[v][2], VEC[v][1], VEC[v][0], $sformatf("R2/R3/R4/R5/R7 vec%0d", v));
        end

        // R4 R5: flags pulsed inside the packet only do not matter
        run_pkt(5, 15, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R4 mid-packet dis ignored");
        run_pkt(5, 15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 mid-packet rev ignored");
        // R7: back-to-back bad then good
        run_pkt(3, 1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 bad before good");
        run_pkt(3, 15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 good clears error");

        // R1: reset from a true status
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(lb_ok, 1'b0, "R1 reset after good");
        check(lb_led_n, 1'b1, "R1 reset led after good");
        rst_n = 1'b1;
        prev_ok = 1'b0;
        run_pkt(2, 15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2 first packet after reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule